// File: doc/BRIEF.md
# Same-Cycle Atomic Update Memory Bank

This block is a small word-addressed memory shared by several requester ports. In any clock cycle, every port may present one operation: a plain read, a plain write, an atomic add that returns the prior contents, an atomic exchange, or an atomic set-to-one that returns the prior contents. Every request presented in a cycle is finished in that cycle, including several requests aimed at the same word. No port is stalled and no port is deferred to a later cycle.

When requests collide on one word, the bank behaves as if they ran one after another in ascending port number. Each port sees the value its predecessors left behind. The word keeps whatever the highest-numbered port in the chain produced. A group of same-cycle atomic adds therefore hands out distinct running totals, and the word ends up holding the full sum.

All atomic kinds share one update datapath, new = f(old, operand), where f is addition, "take the operand" or "constant one". Each response comes back with a valid flag on the following cycle.

Top module: `rmw_bank`

## Requirements
- R1: For each port, the response valid flag is high in the cycle after a valid request and low in the cycle after an idle one.
- R2: Opcode 0 (read) returns the word's current value and leaves the word unchanged.
- R3: Opcode 1 (write) stores the request data into the word and returns zero as response data.
- R4: Opcode 2 (atomic add) returns the old value and leaves old + data modulo 2^DW in the word. There is no overflow indication.
- R5: Opcode 3 (exchange) returns the old value and leaves the request data in the word.
- R6: Opcode 4 (test-and-set) returns the old value and leaves the value 1 in the whole word.
- R7: Same-cycle requests to one word take effect in ascending port order. Each port's returned value is the word as left by all lower-numbered valid ports addressing that word in the same cycle.
- R8: After a cycle of colliding requests, the word holds the result of applying all of them in ascending port order. For atomic adds alone, this is the old value plus the sum of all increments.
- R9: Requests to different words in the same cycle do not affect one another.
- R10: Opcodes 5 to 7 act as a read. They return the current value and never modify the word.
- R11: Synchronous reset clears every word to zero and holds all response valid flags low.
- R12: Port p's fields occupy slice p of each packed request and response bus (bits [p*W +: W], where W is the field width).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORTS | Per-port request valid |
| req_op | input | NPORTS*3 | Per-port opcode |
| req_addr | input | NPORTS*AW | Per-port word address |
| req_data | input | NPORTS*DW | Per-port operand or write data |
| rsp_valid | output | NPORTS | Per-port response valid, one cycle after the request |
| rsp_data | output | NPORTS*DW | Per-port returned value |

## Verification
Each response is due exactly one clock edge after its request, because a single output register stands between the serialization logic and the ports. The memory update lands on that same edge. The bench drives requests on the falling edge and updates its in-order reference model before the rising edge. It compares all response flags and data on the next falling edge. Any word changed by a cycle's requests is checked through read requests issued in the following cycles, whose results again appear one edge later.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   localparam int OP_W  = 3;
   localparam int MAX_W = 64;

   typedef enum logic [OP_W-1:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_FAA   = 3'd2,
      OP_SWAP  = 3'd3,
      OP_TAS   = 3'd4
   } rmw_op_e;

   // Update function shared by every atomic kind; callers truncate to their width.
   function automatic logic [MAX_W-1:0] phi_next(input logic [OP_W-1:0] op,
                                                 input logic [MAX_W-1:0] old_v,
                                                 input logic [MAX_W-1:0] opnd);
      logic [MAX_W-1:0] r;
      case (op)
         OP_STORE: r = opnd;
         OP_FAA:   r = old_v + opnd;
         OP_SWAP:  r = opnd;
         OP_TAS:   r = {{(MAX_W-1){1'b0}}, 1'b1};
         default:  r = old_v;
      endcase
      return r;
   endfunction

   function automatic logic op_writes(input logic [OP_W-1:0] op);
      return (op == OP_STORE) || (op == OP_FAA) || (op == OP_SWAP) || (op == OP_TAS);
   endfunction

endpackage

// File: rtl/rmw_store.sv
module rmw_store #(
   parameter int NPORTS = 4,
   parameter int AW     = 4,
   parameter int DW     = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NPORTS-1:0]    wr_en,
   input  logic [NPORTS*AW-1:0] wr_addr,
   input  logic [NPORTS*DW-1:0] wr_data,
   input  logic [NPORTS*AW-1:0] rd_addr,
   output logic [NPORTS*DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] words [DEPTH];

   // Ascending port loop: the highest enabled port writing a word wins.
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) words[i] <= '0;
      end else begin
         for (int p = 0; p < NPORTS; p++) begin
            if (wr_en[p]) words[wr_addr[p*AW +: AW]] <= wr_data[p*DW +: DW];
         end
      end
   end

   always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
         rd_data[p*DW +: DW] = words[rd_addr[p*AW +: AW]];
      end
   end
endmodule

// File: rtl/rmw_serial.sv
module rmw_serial
   import rmw_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int AW     = 4,
   parameter int DW     = 32
) (
   input  logic [NPORTS-1:0]      req_valid,
   input  logic [NPORTS*OP_W-1:0] req_op,
   input  logic [NPORTS*AW-1:0]   req_addr,
   input  logic [NPORTS*DW-1:0]   req_data,
   input  logic [NPORTS*DW-1:0]   base_val,
   output logic [NPORTS*DW-1:0]   seen_val
);
   generate
      if (NPORTS == 1) begin : g_single
         assign seen_val = base_val;
      end else begin : g_chain
         // Port p's view: stored word folded through every lower port on the same address.
         always_comb begin
            logic [MAX_W-1:0] v;
            for (int p = 0; p < NPORTS; p++) begin
               v = MAX_W'(base_val[p*DW +: DW]);
               for (int q = 0; q < p; q++) begin
                  if (req_valid[q] && (req_addr[q*AW +: AW] == req_addr[p*AW +: AW])) begin
                     v = MAX_W'(phi_next(req_op[q*OP_W +: OP_W], v,
                                         MAX_W'(req_data[q*DW +: DW])) & {{(MAX_W-DW){1'b0}}, {DW{1'b1}}});
                  end
               end
               seen_val[p*DW +: DW] = v[DW-1:0];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rmw_phi.sv
module rmw_phi
   import rmw_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [OP_W-1:0] op,
   input  logic [DW-1:0]   old_val,
   input  logic [DW-1:0]   operand,
   output logic [DW-1:0]   new_val,
   output logic [DW-1:0]   ret_val,
   output logic            writes
);
   logic [MAX_W-1:0] wide;

   always_comb begin
      wide    = phi_next(op, MAX_W'(old_val), MAX_W'(operand));
      new_val = wide[DW-1:0];
      ret_val = (op == OP_STORE) ? '0 : old_val;
      writes  = op_writes(op);
   end
endmodule

// File: rtl/rmw_bank.sv
module rmw_bank
   import rmw_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int AW     = 4,
   parameter int DW     = 32
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NPORTS-1:0]      req_valid,
   input  logic [NPORTS*OP_W-1:0] req_op,
   input  logic [NPORTS*AW-1:0]   req_addr,
   input  logic [NPORTS*DW-1:0]   req_data,
   output logic [NPORTS-1:0]      rsp_valid,
   output logic [NPORTS*DW-1:0]   rsp_data
);
   generate
      if (NPORTS < 1 || NPORTS > 16) begin : g_bad_ports
         $error("rmw_bank: NPORTS must be 1..16");
      end
      if (DW < 2 || DW > MAX_W) begin : g_bad_width
         $error("rmw_bank: DW must be 2..64");
      end
      if (AW < 1 || AW > 10) begin : g_bad_addr
         $error("rmw_bank: AW must be 1..10");
      end
   endgenerate

   logic [NPORTS*DW-1:0] base_w, seen_w, next_w, ret_w;
   logic [NPORTS-1:0]    wr_w;

   rmw_store #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_w & req_valid),
      .wr_addr (req_addr),
      .wr_data (next_w),
      .rd_addr (req_addr),
      .rd_data (base_w)
   );

   rmw_serial #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_serial (
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .base_val  (base_w),
      .seen_val  (seen_w)
   );

   genvar p;
   generate
      for (p = 0; p < NPORTS; p++) begin : g_port
         rmw_phi #(.DW(DW)) u_phi (
            .op      (req_op[p*OP_W +: OP_W]),
            .old_val (seen_w[p*DW +: DW]),
            .operand (req_data[p*DW +: DW]),
            .new_val (next_w[p*DW +: DW]),
            .ret_val (ret_w[p*DW +: DW]),
            .writes  (wr_w[p])
         );

         assert_store_zero_R3: assert property (@(posedge clk) disable iff (rst)
            (req_valid[p] && req_op[p*OP_W +: OP_W] == OP_STORE) |=> rsp_data[p*DW +: DW] == '0);
      end

      for (p = 0; p + 1 < NPORTS; p++) begin : g_pair
         assert_faa_order_R7: assert property (@(posedge clk) disable iff (rst)
            (req_valid[p] && req_valid[p+1]
             && req_op[p*OP_W +: OP_W] == OP_FAA && req_op[(p+1)*OP_W +: OP_W] == OP_FAA
             && req_addr[p*AW +: AW] == req_addr[(p+1)*AW +: AW])
            |=> rsp_data[(p+1)*DW +: DW] == rsp_data[p*DW +: DW] + $past(req_data[p*DW +: DW]));

         assert_store_forward_R7: assert property (@(posedge clk) disable iff (rst)
            (req_valid[p] && req_valid[p+1]
             && req_op[p*OP_W +: OP_W] == OP_STORE && req_op[(p+1)*OP_W +: OP_W] == OP_LOAD
             && req_addr[p*AW +: AW] == req_addr[(p+1)*AW +: AW])
            |=> rsp_data[(p+1)*DW +: DW] == $past(req_data[p*DW +: DW]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= '0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_data  <= ret_w;
      end
   end

   assert_rsp_timing_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> rsp_valid == $past(req_valid));

   assert_reset_quiet_R11: assert property (@(posedge clk)
      rst |=> rsp_valid == '0);

endmodule

// File: tb/rmw_bank_tb.sv
`timescale 1ns/1ps
module rmw_bank_tb;
   import rmw_pkg::*;

   localparam int NP = 4;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                 rst;
   logic [NP-1:0]        req_valid;
   logic [NP*OP_W-1:0]   req_op;
   logic [NP*AW-1:0]     req_addr;
   logic [NP*DW-1:0]     req_data;
   logic [NP-1:0]        rsp_valid;
   logic [NP*DW-1:0]     rsp_data;

   rmw_bank #(.NPORTS(NP), .AW(AW), .DW(DW)) u_dut (
      .clk, .rst, .req_valid, .req_op, .req_addr, .req_data, .rsp_valid, .rsp_data
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] exp_data [NP];
   logic [NP-1:0] exp_valid;
   string exp_tag [NP];
   string ctx = "";

   function automatic string op_tag(input logic [OP_W-1:0] op);
      case (op)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return "R6";
         default: return "R10";
      endcase
   endfunction

   task automatic clear_reqs();
      req_valid = '0; req_op = '0; req_addr = '0; req_data = '0;
   endtask

   task automatic put(input int p, input logic [OP_W-1:0] op,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_valid[p]          = 1'b1;
      req_op[p*OP_W +: OP_W] = op;
      req_addr[p*AW +: AW]  = a;
      req_data[p*DW +: DW]  = d;
   endtask

   // Reference: apply requests one at a time in ascending port order.
   task automatic predict();
      for (int p = 0; p < NP; p++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d, old;
         logic [OP_W-1:0] op;
         bit hit;
         exp_valid[p] = req_valid[p];
         exp_data[p]  = '0;
         exp_tag[p]   = "R1";
         if (req_valid[p]) begin
            a = req_addr[p*AW +: AW];
            d = req_data[p*DW +: DW];
            op = req_op[p*OP_W +: OP_W];
            old = ref_mem[a];
            hit = 0;
            for (int q = 0; q < p; q++)
               if (req_valid[q] && req_addr[q*AW +: AW] == a) hit = 1;
            case (op)
               3'd1: begin exp_data[p] = '0;  ref_mem[a] = d; end
               3'd2: begin exp_data[p] = old; ref_mem[a] = old + d; end
               3'd3: begin exp_data[p] = old; ref_mem[a] = d; end
               3'd4: begin exp_data[p] = old; ref_mem[a] = 32'd1; end
               default: exp_data[p] = old;
            endcase
            exp_tag[p] = (ctx != "") ? ctx : (hit ? "R7" : op_tag(op));
         end
      end
   endtask

   task automatic step();
      predict();
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (rsp_valid !== exp_valid) begin
         errors++;
         $display("FAIL R1 rsp_valid: got %b expected %b", rsp_valid, exp_valid);
      end
      for (int p = 0; p < NP; p++) begin
         if (exp_valid[p]) begin
            checks++;
            if (rsp_data[p*DW +: DW] !== exp_data[p]) begin
               errors++;
               $display("FAIL %s port %0d: got %h expected %h",
                        exp_tag[p], p, rsp_data[p*DW +: DW], exp_data[p]);
            end
         end
      end
      clear_reqs();
   endtask

   task automatic load_all();
      for (int w = 0; w < DEPTH; w += NP) begin
         for (int p = 0; p < NP; p++) put(p, 3'd0, AW'(w + p), 32'h0);
         step();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24680));
      clear_reqs();
      rst = 1'b1;
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== '0) begin
         errors++;
         $display("FAIL R11 rsp_valid in reset: got %b expected 0", rsp_valid);
      end
      rst = 1'b0;

      ctx = "R11"; load_all();

      // R7 / R8: four colliding adds 1,2,3,4 -> returns 0,1,3,6, word 10
      ctx = "";
      for (int p = 0; p < NP; p++) put(p, 3'd2, 4'd5, 32'(p + 1));
      step();
      ctx = "R8"; put(0, 3'd0, 4'd5, 0); step();

      // R6: colliding test-and-set -> 0,1,1,1
      ctx = "R6";
      for (int p = 0; p < NP; p++) put(p, 3'd4, 4'd7, 32'hDEAD);
      step();

      // R5: colliding exchange -> 0,11,22,33, word 44
      ctx = "R5";
      for (int p = 0; p < NP; p++) put(p, 3'd3, 4'd2, 32'(11 * (p + 1)));
      step();
      ctx = "R8"; put(3, 3'd0, 4'd2, 0); step();

      // R3 / R7: store then load on one word in one cycle
      ctx = "R3";
      put(0, 3'd1, 4'd3, 32'h0000ABCD); put(1, 3'd0, 4'd3, 0);
      put(2, 3'd1, 4'd3, 32'h00000055); put(3, 3'd0, 4'd3, 0);
      step();

      // R4: wrap modulo 2^32
      ctx = "R4";
      put(0, 3'd1, 4'd9, 32'hFFFFFFFF); step();
      put(1, 3'd2, 4'd9, 32'd2); step();
      put(2, 3'd0, 4'd9, 0); step();

      // R10: reserved opcodes behave as read
      ctx = "R10";
      put(0, 3'd6, 4'd9, 32'h77); put(1, 3'd5, 4'd9, 32'h88); put(2, 3'd7, 4'd9, 32'h99); step();
      put(3, 3'd0, 4'd9, 0); step();

      // R9: independent words
      ctx = "R9";
      for (int p = 0; p < NP; p++) put(p, 3'd2, AW'(10 + p), 32'(p + 1));
      step();
      for (int p = 0; p < NP; p++) put(p, 3'd0, AW'(10 + p), 0);
      step();

      // R2: reads leave the word unchanged
      ctx = "R2";
      put(0, 3'd0, 4'd5, 0); put(2, 3'd0, 4'd5, 0); step();
      put(1, 3'd0, 4'd5, 0); step();

      // R12: port slices are independent
      ctx = "R12";
      for (int p = 0; p < NP; p++) put(p, 3'd3, AW'(p), 32'hA0A0_0000 | 32'(p));
      step();
      for (int p = 0; p < NP; p++) put(p, 3'd0, AW'(p), 0);
      step();

      // Random collisions
      ctx = "";
      for (int c = 0; c < 3000; c++) begin
         for (int p = 0; p < NP; p++) begin
            if ($urandom_range(0, 9) < 8) begin
               logic [AW-1:0] a;
               a = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, DEPTH - 1))
                                               : AW'($urandom_range(0, 2));
               put(p, OP_W'($urandom_range(0, 5)), a,
                   ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 7)) : $urandom());
            end
         end
         step();
      end

      ctx = "R8"; load_all();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule